// File: doc/BRIEF.md
# FIFO Trigger-Level Crossing Interrupt

This block produces the receive and transmit service interrupts of a serial port. It watches the fill level of the receive and transmit FIFOs at each push or pop and compares the occupancy before and after that step against a programmable trigger level. An interrupt becomes pending only when the occupancy passes the trigger level in the direction that calls for service. For receive, that is when the FIFO fills up to the level. For transmit, that is when the FIFO drains down to the level. An occupancy that merely sits on one side of the level does nothing.

A pending interrupt goes away in three ways. The first is an automatic clear, when software moves the occupancy back across the level: reading drains the receive FIFO below its level, and writing fills the transmit FIFO above its level. The second is an acknowledge from an interrupt-index read that reported the source. The third is an explicit clear strobe. The FIFO storage, the serial engines and the index priority logic sit outside this block. Each FIFO feeds in its occupancy and its push and pop strobes. The occupancy input is the value before the strobes of the same cycle take effect.

Top module: `fifo_lvl_irq`

## Requirements
- R1: The receive flag becomes 1 on the clock edge after a cycle in which the receive occupancy goes from below the receive trigger level to at or above it.
- R2: A push or pop that keeps the occupancy on the same side of the threshold does not set a flag, even when that side is the one that would request service. After transmit service has been acknowledged, further draining does not raise the transmit flag again until the FIFO has been refilled above the level.
- R3: The receive flag clears on the edge after a cycle in which the receive occupancy goes from at or above the level to below it.
- R4: The transmit flag becomes 1 on the edge after a cycle in which the transmit occupancy goes from above the transmit trigger level to at or below it.
- R5: The transmit flag clears on the edge after a cycle in which the transmit occupancy goes from at or below the level to above it.
- R6: A 1 on a source's index-read acknowledge or on its clear strobe clears that source's flag on the next edge.
- R7: A crossing event in the same cycle as an acknowledge or clear for that source leaves the flag set.
- R8: A cycle with both push and pop on a FIFO that is neither empty nor full leaves the occupancy unchanged and produces no event.
- R9: The trigger-level codes map to occupancy thresholds for a FIFO of DEPTH entries (default 4) as follows: 2'b00 gives DEPTH/4, 2'b01 gives DEPTH/2, and 2'b10 and 2'b11 both give 3*DEPTH/4.
- R10: Changing a trigger-level code while no push, pop, acknowledge or clear occurs leaves both flags unchanged.
- R11: A push to a full FIFO without a pop, or a pop from an empty FIFO, is treated as no step and produces no event.
- R12: While the reset is asserted, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W (3) | Receive FIFO occupancy before this cycle's strobes |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_trig_sel | input | 2 | Receive trigger-level code |
| rx_idx_ack | input | 1 | Index read reported the receive source |
| rx_clr | input | 1 | Clear strobe for the receive flag |
| tx_count | input | CNT_W (3) | Transmit FIFO occupancy before this cycle's strobes |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_trig_sel | input | 2 | Transmit trigger-level code |
| tx_idx_ack | input | 1 | Index read reported the transmit source |
| tx_clr | input | 1 | Clear strobe for the transmit flag |
| rx_irq | output | 1 | Receive service interrupt pending |
| tx_irq | output | 1 | Transmit service interrupt pending |

## Verification
The bench builds the block with its default DEPTH of 4, so the three thresholds are 1, 2 and 3. At this depth every occupancy from empty to full is a single push or pop away from a threshold. This lets short sequences cross each threshold in both directions. The same sequences also reach the full and empty saturation cases and the reserved code 2'b11. Trigger levels are switched mid-stream while the occupancy sits between two thresholds, which shows that a code change alone raises nothing and that later crossings follow the new level.

// File: rtl/fli_pkg.sv
package fli_pkg;

  // Trigger-level code, fraction of FIFO depth
  typedef enum logic [1:0] {
    TRIG_QTR  = 2'b00,
    TRIG_HALF = 2'b01,
    TRIG_3QTR = 2'b10,
    TRIG_RSV  = 2'b11
  } trig_e;

  // Direction in which a crossing requests service
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } dir_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/fli_rst_sync.sv
module fli_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fli_thresh.sv
module fli_thresh
  import fli_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  trig_e            sel,
  output logic [CNT_W-1:0] level
);

  localparam logic [CNT_W-1:0] LVL_QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LVL_3QTR = CNT_W'((3 * DEPTH) / 4);

  // R9: code to threshold mapping; reserved code reuses three quarters
  always_comb begin
    unique case (sel)
      TRIG_QTR:  level = LVL_QTR;
      TRIG_HALF: level = LVL_HALF;
      TRIG_3QTR: level = LVL_3QTR;
      default:   level = LVL_3QTR;
    endcase
  end

endmodule

// File: rtl/fli_step.sv
module fli_step
  import fli_pkg::*;
#(
  parameter int   DEPTH = 4,
  parameter int   CNT_W = $clog2(DEPTH + 1),
  parameter dir_e DIR   = DIR_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] level,
  output logic             cross_evt,
  output logic             back_evt
);

  localparam int          EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             pop_ok;
  logic             push_ok;
  logic [EXT_W-1:0] cnt_ext;
  logic [EXT_W-1:0] nxt_ext;
  logic [EXT_W-1:0] lvl_ext;

  // Effective step: R11 ignores pop on empty and push on full
  always_comb begin
    pop_ok  = pop && (count != '0);
    push_ok = push && ((count != FULL) || pop_ok);
    cnt_ext = {1'b0, count};
    lvl_ext = {1'b0, level};
    nxt_ext = cnt_ext + EXT_W'(push_ok) - EXT_W'(pop_ok);
  end

  generate
    if (DIR == DIR_RISE) begin : g_rise
      logic at_old;
      logic at_new;
      always_comb begin
        at_old    = cnt_ext >= lvl_ext;
        at_new    = nxt_ext >= lvl_ext;
        cross_evt = !at_old && at_new;   // R1
        back_evt  = at_old && !at_new;   // R3
      end
    end else begin : g_fall
      logic hi_old;
      logic hi_new;
      always_comb begin
        hi_old    = cnt_ext > lvl_ext;
        hi_new    = nxt_ext > lvl_ext;
        cross_evt = hi_old && !hi_new;   // R4
        back_evt  = !hi_old && hi_new;   // R5
      end
    end
  endgenerate

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cross_evt && back_evt));

  assert_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && (count != '0) && (count != FULL)) |-> (!cross_evt && !back_evt));

  assert_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && (count == FULL)) |-> (!cross_evt && !back_evt));

  assert_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (count == '0)) |-> (!cross_evt && !back_evt));

endmodule

// File: rtl/fli_flag.sv
module fli_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic auto_clr,
  input  logic ack,
  input  logic clr,
  output logic pend
);

  logic clr_any;
  logic pend_en;
  logic pend_nxt;

  // Next state: set has priority over every clear source (R7)
  always_comb begin
    clr_any  = auto_clr || ack || clr;
    pend_en  = set_evt || clr_any;
    pend_nxt = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pend_en) begin
      pend <= pend_nxt;
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && (ack || clr)) |=> !pend);

  // R3 and R5: automatic clear on crossing back
  assert_auto_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && auto_clr) |=> !pend);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !auto_clr && !ack && !clr) |=> $stable(pend));

endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
  import fli_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [1:0]       rx_trig_sel,
  input  logic             rx_idx_ack,
  input  logic             rx_clr,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic [1:0]       tx_trig_sel,
  input  logic             tx_idx_ack,
  input  logic             tx_clr,
  output logic             rx_irq,
  output logic             tx_irq
);

  localparam int CH_RX = 0;
  localparam int CH_TX = 1;

  logic             rst_n_sync;
  logic [CNT_W-1:0] cnt_a   [NUM_CH];
  logic             push_a  [NUM_CH];
  logic             pop_a   [NUM_CH];
  trig_e            sel_a   [NUM_CH];
  logic             ack_a   [NUM_CH];
  logic             clr_a   [NUM_CH];
  logic [CNT_W-1:0] level_a [NUM_CH];
  logic             cross_a [NUM_CH];
  logic             back_a  [NUM_CH];
  logic             pend_a  [NUM_CH];

  fli_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    cnt_a[CH_RX]  = rx_count;
    push_a[CH_RX] = rx_push;
    pop_a[CH_RX]  = rx_pop;
    sel_a[CH_RX]  = trig_e'(rx_trig_sel);
    ack_a[CH_RX]  = rx_idx_ack;
    clr_a[CH_RX]  = rx_clr;
    cnt_a[CH_TX]  = tx_count;
    push_a[CH_TX] = tx_push;
    pop_a[CH_TX]  = tx_pop;
    sel_a[CH_TX]  = trig_e'(tx_trig_sel);
    ack_a[CH_TX]  = tx_idx_ack;
    clr_a[CH_TX]  = tx_clr;
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam dir_e CH_DIR = (ch == CH_RX) ? DIR_RISE : DIR_FALL;

      fli_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thresh (
        .sel   (sel_a[ch]),
        .level (level_a[ch])
      );

      fli_step #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIR(CH_DIR)) u_step (
        .clk       (clk),
        .rst_n     (rst_n_sync),
        .count     (cnt_a[ch]),
        .push      (push_a[ch]),
        .pop       (pop_a[ch]),
        .level     (level_a[ch]),
        .cross_evt (cross_a[ch]),
        .back_evt  (back_a[ch])
      );

      fli_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n_sync),
        .set_evt  (cross_a[ch]),
        .auto_clr (back_a[ch]),
        .ack      (ack_a[ch]),
        .clr      (clr_a[ch]),
        .pend     (pend_a[ch])
      );

      assert_trig_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (!$stable(sel_a[ch]) && !push_a[ch] && !pop_a[ch] && !ack_a[ch] && !clr_a[ch])
        |=> $stable(pend_a[ch]));
    end
  endgenerate

  assign rx_irq = pend_a[CH_RX];
  assign tx_irq = pend_a[CH_TX];

  assert_rx_set_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!rx_irq && $past(cross_a[CH_RX])) |-> 1'b0);

  assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!tx_irq && $past(cross_a[CH_TX])) |-> 1'b0);

endmodule

// File: tb/fifo_lvl_irq_test.sv
module fifo_lvl_irq_test;

  localparam int DEPTH = 4;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic [2:0] rc;
    logic       rpu;
    logic       rpo;
    logic [1:0] rs;
    logic [2:0] tc;
    logic       tpu;
    logic       tpo;
    logic [1:0] ts;
    logic       rak;
    logic       rcl;
    logic       tak;
    logic       tcl;
    logic       erx;
    logic       etx;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 36;
  // fields: rc rpu rpo rs | tc tpu tpo ts | rak rcl tak tcl | erx etx | req
  localparam vec_t TBL [0:NV-1] = '{
    '{3'd1,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd1},
    '{3'd2,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd6},
    '{3'd3,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd4,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd11},
    '{3'd4,1'b0,1'b1,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd3,1'b1,1'b1,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd8},
    '{3'd3,1'b0,1'b1,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd2,1'b0,1'b1,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3},
    '{3'd1,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd1},
    '{3'd2,1'b0,1'b1,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3},
    '{3'd1,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd1},
    '{3'd2,1'b0,1'b0,2'd0, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd10},
    '{3'd2,1'b0,1'b1,2'd0, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd9},
    '{3'd1,1'b0,1'b1,2'd0, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd9},
    '{3'd0,1'b0,1'b1,2'd2, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd11},
    '{3'd2,1'b1,1'b0,2'd2, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd9},
    '{3'd3,1'b0,1'b1,2'd3, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd9},
    '{3'd2,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd1,1'b1,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd7},
    '{3'd2,1'b0,1'b0,2'd1, 3'd4,1'b0,1'b0,2'd1, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd6},
    '{3'd0,1'b0,1'b0,2'd1, 3'd3,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd4},
    '{3'd0,1'b0,1'b0,2'd1, 3'd2,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd4},
    '{3'd0,1'b0,1'b0,2'd1, 3'd1,1'b1,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd5},
    '{3'd0,1'b0,1'b0,2'd1, 3'd2,1'b1,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd5},
    '{3'd0,1'b0,1'b0,2'd1, 3'd3,1'b1,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd8},
    '{3'd0,1'b0,1'b0,2'd1, 3'd3,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd4},
    '{3'd0,1'b0,1'b0,2'd1, 3'd2,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd6},
    '{3'd0,1'b0,1'b0,2'd1, 3'd2,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd0,1'b0,1'b0,2'd1, 3'd1,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd0,1'b0,1'b0,2'd1, 3'd0,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd11},
    '{3'd0,1'b0,1'b0,2'd1, 3'd0,1'b1,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2},
    '{3'd0,1'b0,1'b0,2'd1, 3'd1,1'b0,1'b0,2'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd10},
    '{3'd0,1'b0,1'b0,2'd1, 3'd2,1'b0,1'b1,2'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd9},
    '{3'd0,1'b0,1'b0,2'd1, 3'd1,1'b0,1'b1,2'd0, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd6},
    '{3'd0,1'b0,1'b0,2'd1, 3'd3,1'b0,1'b1,2'd1, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'd7},
    '{3'd1,1'b1,1'b0,2'd1, 3'd2,1'b0,1'b0,2'd1, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd1}
  };

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] rx_count;
  logic             rx_push;
  logic             rx_pop;
  logic [1:0]       rx_trig_sel;
  logic             rx_idx_ack;
  logic             rx_clr;
  logic [CNT_W-1:0] tx_count;
  logic             tx_push;
  logic             tx_pop;
  logic [1:0]       tx_trig_sel;
  logic             tx_idx_ack;
  logic             tx_clr;
  logic             rx_irq;
  logic             tx_irq;

  int checks;
  int errors;

  fifo_lvl_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_count    (rx_count),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_trig_sel (rx_trig_sel),
    .rx_idx_ack  (rx_idx_ack),
    .rx_clr      (rx_clr),
    .tx_count    (tx_count),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .tx_trig_sel (tx_trig_sel),
    .tx_idx_ack  (tx_idx_ack),
    .tx_clr      (tx_clr),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_count = 3'd0; rx_push = 1'b0; rx_pop = 1'b0; rx_trig_sel = 2'd1;
    rx_idx_ack = 1'b0; rx_clr = 1'b0;
    tx_count = 3'd4; tx_push = 1'b0; tx_pop = 1'b0; tx_trig_sel = 2'd1;
    tx_idx_ack = 1'b0; tx_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 rx_irq in reset", rx_irq, 1'b0);
    check("R12 tx_irq in reset", tx_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    check("R12 rx_irq after release", rx_irq, 1'b0);
    check("R12 tx_irq after release", tx_irq, 1'b0);

    // Table walk: drive at falling edge, result due after the next rising edge
    for (int i = 0; i < NV; i++) begin
      rx_count = TBL[i].rc;  rx_push = TBL[i].rpu; rx_pop = TBL[i].rpo;
      rx_trig_sel = TBL[i].rs; rx_idx_ack = TBL[i].rak; rx_clr = TBL[i].rcl;
      tx_count = TBL[i].tc;  tx_push = TBL[i].tpu; tx_pop = TBL[i].tpo;
      tx_trig_sel = TBL[i].ts; tx_idx_ack = TBL[i].tak; tx_clr = TBL[i].tcl;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec %0d rx_irq", TBL[i].req, i), rx_irq, TBL[i].erx);
      check($sformatf("R%0d vec %0d tx_irq", TBL[i].req, i), tx_irq, TBL[i].etx);
    end

    // Directed: R12 async reset while rx flag is pending
    idle_inputs();
    check("R1 rx pending before reset", rx_irq, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R12 rx_irq cleared by async reset", rx_irq, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // Directed: R10 code sweep with no traffic keeps flags at 0
    for (int s = 0; s < 4; s++) begin
      rx_count = 3'd2; tx_count = 3'd2;
      rx_trig_sel = 2'(s); tx_trig_sel = 2'(3 - s);
      @(posedge clk);
      @(negedge clk);
      check("R10 rx_irq code sweep", rx_irq, 1'b0);
      check("R10 tx_irq code sweep", tx_irq, 1'b0);
    end

    // Directed: R9 reserved code 2'b11 on transmit behaves as threshold 3
    tx_trig_sel = 2'd3; tx_count = 3'd4; tx_pop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 tx reserved code crossing 4->3", tx_irq, 1'b1);
    tx_pop = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule